// File: doc/BRIEF.md
# Display Serial Interface Init Command Packetizer

The block turns a list of panel initialisation commands into command-mode packet words for one or more display serial interface link controllers. Commands arrive one byte per beat on a valid/ready stream. The last byte of a command carries an end marker. A separate zero marker beat stands for a command of length zero, and that beat ends the list. The block stores the whole command. It then writes it to each link controller in turn, from link 0 upward, through two FIFO write ports per link: one for 32-bit header words and one for 32-bit payload words.

The packet format depends on the byte count. A one-byte command becomes a short write with no parameter. A two-byte command becomes a short write with one parameter. A command of three or more bytes becomes a long write: its payload words go out first, and the header carrying the byte count follows. After every command the block writes a no-operation short write on the same link, so that the panel takes in the command before the next one arrives.

Every write waits while the target FIFO reports full. If a FIFO stays full for the configured 20 ms timeout, counted in clock cycles, the block stops all traffic and raises a sticky error.

Top module: `dsi_cmd_packer`

## Requirements
- R1: A one-byte command gives the header word {8'h00, 8'h00, byte0, 2'b00, 6'h05}. The data type is in bits 5:0, the virtual channel (always 0) in bits 7:6, and the 16-bit data field in bits 23:8. Bits 31:24 are zero.
- R2: A two-byte command gives the header {8'h00, byte1, byte0, 2'b00, 6'h15}. The first byte is in bits 15:8 and the second byte in bits 23:16.
- R3: A command of L >= 3 bytes gives the header {8'h00, L[15:0], 2'b00, 6'h39}. L may not exceed MAX_BYTES.
- R4: A long command writes ceil(L/4) payload words. Byte 4w+k of the command goes in bits 8k+7:8k of word w. Bytes past L are zero.
- R5: On each link, all payload words of a long command are written before its header word.
- R6: On each link, each command header is followed by the no-operation header 32'h0000_0005.
- R7: Each command, with its no-operation header, goes to link 0, then link 1, and so on up to link LINKS-1. At most one write strobe is high in any cycle.
- R8: No write is made to a FIFO while its full input is high. The word waits until full falls.
- R9: If a FIFO stays full for TMO = CLK_HZ/1000*TIMEOUT_MS consecutive cycles while a word waits for it, err rises and stays high until reset. After that there are no writes and in_ready stays low. A wait of TMO-1 cycles causes no error.
- R10: A zero-marker beat (in_zero=1) at a command boundary ends the list. It causes no FIFO writes and gives a one-cycle pulse on list_done one cycle after acceptance.
- R11: A zero-marker beat after some bytes of an unfinished command, or a byte beyond MAX_BYTES, raises err.
- R12: After reset in_ready=1, err=0, list_done=0 and no write strobe is high. in_ready is low from the cycle after a command's last byte until that command has gone out on all links.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts a beat |
| in_data | input | 8 | Command byte |
| in_last | input | 1 | Beat carries the last byte of a command |
| in_zero | input | 1 | Zero-length marker beat (its data is ignored) |
| cmd_wr | output | LINKS | Header FIFO write strobe, one bit per link |
| cmd_word | output | 32 | Header word |
| cmd_full | input | LINKS | Header FIFO full, one bit per link |
| pld_wr | output | LINKS | Payload FIFO write strobe, one bit per link |
| pld_word | output | 32 | Payload word |
| pld_full | input | LINKS | Payload FIFO full, one bit per link |
| err | output | 1 | Sticky error (timeout or malformed list) |
| list_done | output | 1 | One-cycle pulse when the list terminator is accepted |

## Verification
Every command length from 1 to MAX_BYTES is sent twice: once with the FIFOs always free, and once with short full patterns that differ per link. This sweep separates the three header formats at the 1/2/3-byte boundaries. It also separates the zero-padding of each payload residue (L mod 4) and the payload-before-header order. The back-pressure pass shows that stalls move writes in time but do not change their content or order.

The timeout is tested with full held for exactly TMO-1 cycles and then for TMO cycles, which pins down where the error starts. Malformed lists are also tested: a zero marker in mid-command and an oversized command. These show that the error stops the block for good, while a correct terminator only gives a pulse.

// File: rtl/dsi_cmd_packer.sv
module dsi_cmd_packer #(
  parameter int LINKS      = 2,
  parameter int MAX_BYTES  = 64,
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_MS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_zero,
  output logic [LINKS-1:0] cmd_wr,
  output logic [31:0]      cmd_word,
  input  logic [LINKS-1:0] cmd_full,
  output logic [LINKS-1:0] pld_wr,
  output logic [31:0]      pld_word,
  input  logic [LINKS-1:0] pld_full,
  output logic             err,
  output logic             list_done
);
  localparam int TMO = CLK_HZ / 1000 * TIMEOUT_MS;
  localparam int CW  = $clog2(MAX_BYTES + 1);
  localparam int AW  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int LW  = (LINKS > 1) ? $clog2(LINKS) : 1;

  typedef enum logic [2:0] {COLLECT, PAYLOAD, HEADER, NOP, HALT} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [15:0]  widx;
  logic [LW-1:0] link;
  logic [31:0]  tmr;
  logic         done_q;
  logic [7:0]   mem [MAX_BYTES];

  logic [15:0] len16, nwords;
  logic        is_pld, is_cmd, stall;

  assign len16    = 16'(cnt);
  assign nwords   = (len16 + 16'd3) >> 2;
  assign is_pld   = (st == PAYLOAD);
  assign is_cmd   = (st == HEADER) || (st == NOP);
  assign stall    = is_pld ? pld_full[link] : cmd_full[link];
  assign in_ready = (st == COLLECT);
  assign err      = (st == HALT);
  assign list_done = done_q;
  assign cmd_wr   = (is_cmd && !stall) ? (LINKS'(1) << link) : '0;
  assign pld_wr   = (is_pld && !stall) ? (LINKS'(1) << link) : '0;

  always_comb begin
    if (st == NOP)        cmd_word = {8'h00, 16'h0000, 2'b00, 6'h05};
    else if (cnt == CW'(1)) cmd_word = {8'h00, 8'h00, mem[0], 2'b00, 6'h05};
    else if (cnt == CW'(2)) cmd_word = {8'h00, mem[1], mem[0], 2'b00, 6'h15};
    else                  cmd_word = {8'h00, len16, 2'b00, 6'h39};
  end

  always_comb begin
    pld_word = '0;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] bi;
      bi = {widx[13:0], 2'(k)};
      if (bi < len16) pld_word[8*k +: 8] = mem[bi[AW-1:0]];
    end
  end

  always_ff @(posedge clk)
    if (st == COLLECT && in_valid && !in_zero && cnt < CW'(MAX_BYTES))
      mem[cnt[AW-1:0]] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= COLLECT; cnt <= '0; widx <= '0; link <= '0; tmr <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        COLLECT: if (in_valid) begin
          if (in_zero) begin
            if (cnt != '0) st <= HALT;
            else           done_q <= 1'b1;
          end else if (cnt == CW'(MAX_BYTES)) begin
            st <= HALT;
          end else begin
            cnt <= cnt + CW'(1);
            if (in_last) begin
              link <= '0; widx <= '0; tmr <= '0;
              st <= (cnt >= CW'(2)) ? PAYLOAD : HEADER;
            end
          end
        end
        PAYLOAD, HEADER, NOP: if (stall) begin
          if (tmr == 32'(TMO - 1)) st <= HALT;
          else                     tmr <= tmr + 32'd1;
        end else begin
          tmr <= '0;
          if (st == PAYLOAD) begin
            widx <= widx + 16'd1;
            if (widx == nwords - 16'd1) st <= HEADER;
          end else if (st == HEADER) begin
            st <= NOP;
          end else if (link == LW'(LINKS - 1)) begin
            st <= COLLECT; cnt <= '0;
          end else begin
            link <= link + LW'(1); widx <= '0;
            st <= (cnt >= CW'(3)) ? PAYLOAD : HEADER;
          end
        end
        default: st <= HALT;
      endcase
    end
  end
endmodule

module dsi_cmd_packer_chk #(parameter int LINKS = 2) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic [LINKS-1:0] cmd_wr,
  input logic [LINKS-1:0] cmd_full,
  input logic [LINKS-1:0] pld_wr,
  input logic [LINKS-1:0] pld_full,
  input logic             err,
  input logic             list_done
);
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_wr & cmd_full) == '0) && ((pld_wr & pld_full) == '0));
  p_one_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wr, pld_wr}));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_quiet_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cmd_wr == '0 && pld_wr == '0 && !in_ready));
  p_idle_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cmd_wr == '0 && pld_wr == '0));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |=> !list_done);
endmodule

bind dsi_cmd_packer dsi_cmd_packer_chk #(.LINKS(LINKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .cmd_wr(cmd_wr),
  .cmd_full(cmd_full), .pld_wr(pld_wr), .pld_full(pld_full),
  .err(err), .list_done(list_done));

// File: tb/dsi_cmd_packer_bench.sv
module dsi_cmd_packer_bench;
  localparam int LINKS = 2;
  localparam int MAXB  = 16;
  localparam int TMO   = 20;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_zero = 0;
  logic [7:0] in_data = 0;
  logic in_ready, err, list_done;
  logic [LINKS-1:0] cmd_wr, pld_wr, cmd_full, pld_full;
  logic [LINKS-1:0] man_cmd = 0, man_pld = 0, pat_cmd, pat_pld;
  logic [31:0] cmd_word, pld_word;
  logic pat_on = 0;
  int cyc = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dsi_cmd_packer #(.LINKS(LINKS), .MAX_BYTES(MAXB), .CLK_HZ(1000), .TIMEOUT_MS(20))
  u_dsi_cmd_packer (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_zero(in_zero), .cmd_wr(cmd_wr),
    .cmd_word(cmd_word), .cmd_full(cmd_full), .pld_wr(pld_wr), .pld_word(pld_word),
    .pld_full(pld_full), .err(err), .list_done(list_done));

  for (genvar l = 0; l < LINKS; l++) begin : g_pat
    assign pat_cmd[l] = ((cyc + l) % 3) == 0;
    assign pat_pld[l] = ((cyc + l) % 5) < 2;
  end
  assign cmd_full = pat_on ? pat_cmd : man_cmd;
  assign pld_full = pat_on ? pat_pld : man_pld;

  int ev_n = 0;
  bit ev_cmd [64];
  int ev_link [64];
  logic [31:0] ev_data [64];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    #5;
    for (int l = 0; l < LINKS; l++) begin
      if (cmd_wr[l] || pld_wr[l]) begin
        checks++;
        if ((cmd_wr[l] && cmd_full[l]) || (pld_wr[l] && pld_full[l])) begin
          fails++;
          $display("FAIL R8 write while full link %0d: got wr=%b/%b full=%b/%b expected no write",
                   l, cmd_wr, pld_wr, cmd_full, pld_full);
        end
        if (ev_n < 64) begin
          ev_cmd[ev_n] = cmd_wr[l];
          ev_link[ev_n] = l;
          ev_data[ev_n] = cmd_wr[l] ? cmd_word : pld_word;
        end
        ev_n++;
      end
    end
  end

  function automatic logic [7:0] pbyte(int len, int i);
    return 8'((len * 16 + i * 7 + 1) & 255);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; in_zero = 0; in_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_byte(logic [7:0] d, logic last, logic zero);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d; in_last = last; in_zero = zero;
    @(negedge clk);
    in_valid = 0; in_last = 0; in_zero = 0;
  endtask

  task automatic send_cmd(int len);
    for (int i = 0; i < len; i++) send_byte(pbyte(len, i), i == len - 1, 1'b0);
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); #8; n++; end while (!in_ready && n < 500);
  endtask

  task automatic run_len(int len, string mode);
    int k = 0;
    int nw = (len + 3) / 4;
    logic [31:0] w, hdr;
    string tag;
    ev_n = 0;
    send_cmd(len);
    wait_idle();
    check($sformatf("R7 event count len=%0d %s", len, mode), ev_n, LINKS * (len >= 3 ? nw + 2 : 2));
    for (int l = 0; l < LINKS; l++) begin
      if (len >= 3)
        for (int j = 0; j < nw; j++) begin
          w = 0;
          for (int b = 0; b < 4; b++)
            if (4 * j + b < len) w[8*b +: 8] = pbyte(len, 4 * j + b);
          if (k < 64) begin
            check($sformatf("R5 kind pld len=%0d w%0d %s", len, j, mode), 32'(ev_cmd[k]), 0);
            check($sformatf("R7 link len=%0d %s", len, mode), ev_link[k], l);
            check($sformatf("R4 payload len=%0d w%0d %s", len, j, mode), ev_data[k], w);
          end
          k++;
        end
      if (len == 1) begin hdr = {16'h0, pbyte(len, 0), 8'h05}; tag = "R1"; end
      else if (len == 2) begin hdr = {8'h0, pbyte(len, 1), pbyte(len, 0), 8'h15}; tag = "R2"; end
      else begin hdr = {8'h0, 16'(len), 8'h39}; tag = "R3"; end
      if (k + 1 < 64) begin
        check($sformatf("R5 kind hdr len=%0d %s", len, mode), 32'(ev_cmd[k]), 1);
        check($sformatf("%s header len=%0d link %0d %s", tag, len, l, mode), ev_data[k], hdr);
        check($sformatf("R7 link len=%0d %s", len, mode), ev_link[k], l);
        check($sformatf("R6 nop kind len=%0d %s", len, mode), 32'(ev_cmd[k+1]), 1);
        check($sformatf("R6 nop word len=%0d %s", len, mode), ev_data[k+1], 32'h0000_0005);
        check($sformatf("R7 nop link len=%0d %s", len, mode), ev_link[k+1], l);
      end
      k += 2;
    end
    check($sformatf("R9 no error len=%0d %s", len, mode), 32'(err), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got no end expected end of run");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk); #5;
    check("R12 reset in_ready", 32'(in_ready), 1);
    check("R12 reset err", 32'(err), 0);
    check("R12 reset list_done", 32'(list_done), 0);
    check("R12 reset strobes", {28'h0, cmd_wr, pld_wr}, 0);

    for (int len = 1; len <= MAXB; len++) run_len(len, "free");
    pat_on = 1;
    for (int len = 1; len <= MAXB; len++) run_len(len, "backpressure");
    pat_on = 0;

    // R12: in_ready drops after the last byte
    ev_n = 0;
    send_byte(8'h11, 1'b1, 1'b0);
    #5;
    check("R12 in_ready low while emitting", 32'(in_ready), 0);
    wait_idle();

    // R10 terminator at boundary
    ev_n = 0;
    send_byte(8'hAA, 1'b0, 1'b1);
    #5;
    check("R10 list_done pulse", 32'(list_done), 1);
    @(negedge clk); #5;
    check("R10 list_done one cycle", 32'(list_done), 0);
    check("R10 no writes on terminator", ev_n, 0);
    check("R10 no error on terminator", 32'(err), 0);

    // R9 wait of TMO-1 cycles: no error
    ev_n = 0;
    man_cmd = '1;
    send_byte(8'h3C, 1'b1, 1'b0);
    repeat (TMO - 1) @(negedge clk);
    man_cmd = '0;
    wait_idle();
    check("R9 TMO-1 stall no error", 32'(err), 0);
    check("R9 TMO-1 stall traffic delivered", ev_n, 2 * LINKS);

    // R9 wait of TMO cycles: sticky error, traffic stops
    ev_n = 0;
    man_cmd = '1;
    send_byte(8'h3C, 1'b1, 1'b0);
    repeat (TMO) @(negedge clk);
    man_cmd = '0;
    repeat (3) @(negedge clk); #5;
    check("R9 timeout raises err", 32'(err), 1);
    repeat (20) @(negedge clk); #5;
    check("R9 err sticky", 32'(err), 1);
    check("R9 in_ready low after err", 32'(in_ready), 0);
    check("R9 no writes after err", ev_n, 0);

    // R11 zero marker mid-command
    do_reset();
    ev_n = 0;
    send_byte(8'h01, 1'b0, 1'b0);
    send_byte(8'h00, 1'b0, 1'b1);
    #5;
    check("R11 zero mid-command err", 32'(err), 1);
    check("R11 no writes", ev_n, 0);

    // R11 oversize command
    do_reset();
    ev_n = 0;
    for (int i = 0; i < MAXB; i++) send_byte(8'(i), 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1; in_data = 8'hFF; in_last = 1;
    @(negedge clk);
    in_valid = 0; in_last = 0;
    #5;
    check("R11 oversize err", 32'(err), 1);
    check("R11 oversize no writes", ev_n, 0);

    do_reset();
    run_len(5, "after reset");
    finish_run();
  end
endmodule